// File: doc/BRIEF.md
# Glitch-Free Power-of-Two Clock Prescaler

This block turns a fast timing reference into a slower system clock whose rate software picks at run time. `clk_i` is a reference running at twice the undivided clock rate. A setting code k (0 to 8) makes every high phase and every low phase of `sclk_o` last 2^k cycles of `clk_i`. Code 0 is therefore the undivided rate (half of `clk_i`), and code 8 divides that rate by 256. A companion enable, `clk_en_o`, marks the single `clk_i` cycle just before each rising edge of `sclk_o`. Logic that runs on `clk_i` can use it as a clock enable in place of the derived clock.

A setting write is protected. Software first issues an unlock write, then writes the code within a short window. The accepted code waits as pending and is switched in only where a low phase ends, so the output is never cut short. Every phase during a handover runs to its full old or its full new length. The output therefore never runs faster than either setting. The divided clock can also drive a pin in place of that pin's normal data output, and it keeps toggling while reset is held.

Top module: `clk_prescaler`

## Requirements
- R1: Reset selects code 0. After `rst_ni` is released, `sclk_o` alternates level on every `clk_i` cycle, and `clk_en_o` is high on every other cycle.
- R2: With code k in the range 0 to 8, every phase of `sclk_o` lasts 2^k `clk_i` cycles, so the period is 2^(k+1) cycles. Codes 9 to 15 behave exactly like code 0.
- R3: `wdata_i` bit 4 set marks an unlock write, and its bits 3:0 are ignored. `wdata_i` bit 4 clear marks a setting write that carries the code in bits 3:0. A setting write is accepted only when its strobe falls 1 to 4 cycles after an unlock strobe. Any other setting write is ignored. An accepted setting write closes the window at once.
- R4: Every completed phase of `sclk_o` has exactly the length of the old setting or of the new setting. No phase is shorter than the shorter of the two.
- R5: A new setting becomes active only at a rising edge of `sclk_o` that ends a low phase. The first phase at the new length is a high phase. It begins between 1 and 2·2^k_old cycles after the strobe of the accepted write.
- R6: `clk_en_o` is high for exactly the one `clk_i` cycle that precedes each rising edge of `sclk_o`, and at no other time.
- R7: While `clko_en_i` is high, `clko_o` equals `sclk_o`. While it is low, `clko_o` equals `io_out_i`.
- R8: While `rst_ni` is low, `sclk_o` keeps toggling at the code-0 rate, and `clko_o` forwards it whenever `clko_en_i` is high.
- R9: If a second setting is accepted before a pending one has been switched in, only the later one takes effect. The earlier code never appears as a phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing reference, twice the undivided clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset of the setting state |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 5 | Bit 4: unlock flag; bits 3:0: setting code |
| clko_en_i | input | 1 | Selects the divided clock onto the pin |
| io_out_i | input | 1 | Normal data output for the pin |
| sclk_o | output | 1 | Divided system clock |
| clk_en_o | output | 1 | One-cycle pulse before each rising edge of `sclk_o` |
| clko_o | output | 1 | Pin output: divided clock or normal data |

## Verification
On every cycle, the assertions check four things. Each completed phase matches the setting that was active while it ran. The active setting changes only together with a rising edge. The enable pulse and the rising edges pair up one to one. The pin follows its selected source. Only the bench's scenarios can show the behaviours that depend on write timing: the unlock window and its exact last accepted slot, the closing of the window after an accepted write, and a pending setting being overridden. They also cover the latency bound measured from the write strobe, the aliasing of reserved codes, and the clock running on through reset.

// File: rtl/ckp_pkg.sv
package ckp_pkg;
  localparam int unsigned CODE_W_DEF    = 4;
  localparam int unsigned MAX_SHIFT_DEF = 8;
  localparam int unsigned WIN_LEN_DEF   = 4;
  localparam int unsigned SH_W_DEF      = $clog2(MAX_SHIFT_DEF + 1);
endpackage

// File: rtl/ckp_wr_gate.sv
module ckp_wr_gate #(
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned MAX_SHIFT = 8,
  parameter int unsigned WIN_LEN   = 4,
  parameter int unsigned SH_W      = $clog2(MAX_SHIFT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CODE_W:0]   wdata_i,
  output logic              acc_o,
  output logic [SH_W-1:0]   shift_o
);
  localparam int unsigned WC_W = $clog2(WIN_LEN + 1);

  logic [WC_W-1:0]   win_q;
  logic [CODE_W-1:0] code;
  logic              unlock_wr, set_wr;

  assign code      = wdata_i[CODE_W-1:0];
  assign unlock_wr = wr_i &  wdata_i[CODE_W];
  assign set_wr    = wr_i & ~wdata_i[CODE_W];
  assign acc_o     = set_wr & (win_q != '0);

  // reserved codes alias to the undivided setting
  assign shift_o = (32'(code) > MAX_SHIFT) ? '0 : SH_W'(code);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             win_q <= '0;
    else if (unlock_wr)      win_q <= WC_W'(WIN_LEN);
    else if (acc_o)          win_q <= '0;
    else if (win_q != '0)    win_q <= win_q - 1'b1;
  end
endmodule

// File: rtl/ckp_phase_div.sv
module ckp_phase_div #(
  parameter int unsigned MAX_SHIFT = 8,
  parameter int unsigned SH_W      = $clog2(MAX_SHIFT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_i,
  input  logic [SH_W-1:0] shift_i,
  output logic            sclk_o,
  output logic            clk_en_o,
  output logic [SH_W-1:0] cur_o
);
  logic [MAX_SHIFT-1:0] cnt_q, lim;
  logic [SH_W-1:0]      cur_q, pend_q;
  logic                 pend_vld_q, sclk_q, last, apply;

  assign lim   = ~({MAX_SHIFT{1'b1}} << cur_q);
  assign last  = (cnt_q >= lim);
  // switch only where a low phase completes
  assign apply = last & ~sclk_q & pend_vld_q;

  // free-running phase counter: no reset so the clock keeps running in reset
  always_ff @(posedge clk_i) begin
    if (last) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      if (apply) cur_q <= pend_q;
      if (acc_i) begin
        pend_q     <= shift_i;
        pend_vld_q <= 1'b1;
      end else if (apply) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign clk_en_o = last & ~sclk_q;
  assign cur_o    = cur_q;
endmodule

// File: rtl/ckp_pin_mux.sv
module ckp_pin_mux #(
  parameter bit HAS_CLKO = 1'b1
) (
  input  logic sclk_i,
  input  logic clko_en_i,
  input  logic io_out_i,
  output logic pin_o
);
  generate
    if (HAS_CLKO) begin : g_clko
      assign pin_o = clko_en_i ? sclk_i : io_out_i;
    end else begin : g_io_only
      assign pin_o = io_out_i;
    end
  endgenerate
endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler
  import ckp_pkg::*;
#(
  parameter int unsigned CODE_W    = CODE_W_DEF,
  parameter int unsigned MAX_SHIFT = MAX_SHIFT_DEF,
  parameter int unsigned WIN_LEN   = WIN_LEN_DEF,
  parameter bit          HAS_CLKO  = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [CODE_W:0] wdata_i,
  input  logic            clko_en_i,
  input  logic            io_out_i,
  output logic            sclk_o,
  output logic            clk_en_o,
  output logic            clko_o
);
  localparam int unsigned SH_W = $clog2(MAX_SHIFT + 1);

  logic            acc;
  logic [SH_W-1:0] shift, cur_shift;

  ckp_wr_gate #(
    .CODE_W(CODE_W), .MAX_SHIFT(MAX_SHIFT), .WIN_LEN(WIN_LEN), .SH_W(SH_W)
  ) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i),
    .acc_o(acc), .shift_o(shift)
  );

  ckp_phase_div #(
    .MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W)
  ) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .shift_i(shift),
    .sclk_o(sclk_o), .clk_en_o(clk_en_o), .cur_o(cur_shift)
  );

  ckp_pin_mux #(
    .HAS_CLKO(HAS_CLKO)
  ) u_pin (
    .sclk_i(sclk_o), .clko_en_i(clko_en_i), .io_out_i(io_out_i), .pin_o(clko_o)
  );
endmodule

// File: rtl/ckp_checker.sv
module ckp_checker
  import ckp_pkg::*;
#(
  parameter int unsigned MAX_SHIFT = MAX_SHIFT_DEF,
  parameter int unsigned SH_W      = $clog2(MAX_SHIFT + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clko_en_i,
  input logic            io_out_i,
  input logic            sclk_o,
  input logic            clk_en_o,
  input logic            clko_o,
  input logic [SH_W-1:0] cur_i
);
  logic                 sclk_d, armed_q;
  logic [MAX_SHIFT+1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d  <= 1'b0;
      armed_q <= 1'b0;
      run_q   <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (sclk_o != sclk_d) begin
        run_q   <= 1;
        armed_q <= 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  p_shift_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cur_i) <= MAX_SHIFT);

  p_phase_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && (sclk_o != sclk_d)) |-> (32'(run_q) == (32'd1 << $past(cur_i))));

  p_apply_at_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i != $past(cur_i)) |-> (sclk_o && !sclk_d));

  p_en_before_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |=> (sclk_o && !$past(sclk_o)));

  p_rise_after_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && !$past(sclk_o)) |-> $past(clk_en_o));

  p_pin_clk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clko_en_i |-> (clko_o == sclk_o));

  p_pin_io_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clko_en_i |-> (clko_o == io_out_i));
endmodule

bind clk_prescaler ckp_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clko_en_i(clko_en_i), .io_out_i(io_out_i),
  .sclk_o(sclk_o), .clk_en_o(clk_en_o), .clko_o(clko_o), .cur_i(cur_shift)
);

// File: tb/clk_prescaler_bench.sv
module clk_prescaler_bench;
  localparam int MAXP = 8192;

  logic       clk = 1'b0, rst_n = 1'b0, wr = 1'b0, clko_en = 1'b0, io_out = 1'b0;
  logic [4:0] wdata = '0;
  logic       sclk, en, clko;

  clk_prescaler u_clk_prescaler (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata),
    .clko_en_i(clko_en), .io_out_i(io_out),
    .sclk_o(sclk), .clk_en_o(en), .clko_o(clko)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // phase monitor, sampled away from the active edge
  int   ph_len[MAXP];
  int   ph_start[MAXP];
  bit   ph_lvl[MAXP];
  int   ph_n = 0, run = 0, cur_start = 0;
  logic last_s = 1'b0;
  always @(negedge clk) begin
    if (sclk !== last_s) begin
      if (ph_n < MAXP) begin
        ph_len[ph_n]   = run;
        ph_lvl[ph_n]   = last_s;
        ph_start[ph_n] = cur_start;
      end
      ph_n++;
      run       = 1;
      cur_start = cyc;
    end else begin
      run++;
    end
    last_s = sclk;
  end

  int n_chk = 0, n_fail = 0, cur_k = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_word(input logic [4:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  // all phases after the mark have the current length
  task automatic steady(input string req);
    int hk, i0, bad, cnt, badv;
    hk = 1 << cur_k; i0 = ph_n; bad = 0; cnt = 0; badv = 0;
    idle(6 * hk + 4);
    for (int i = i0 + 1; i < ph_n; i++) begin
      cnt++;
      if (ph_len[i] != hk) begin bad++; badv = ph_len[i]; end
    end
    chk(cnt >= 3, {req, " phase count"}, cnt, 3);
    chk(bad == 0, {req, " phase length"}, badv, hk);
  endtask

  task automatic change(input logic [3:0] code, input int newk, input int gap,
                        input bit extra_en, input logic [3:0] extra, input string req);
    int ho, hn, i0, w, f, lat, bad, badv, cnt;
    ho = 1 << cur_k; hn = 1 << newk; i0 = ph_n;
    wr_word(5'h10);
    idle(gap);
    wr_word({1'b0, code});
    w = cyc;
    if (extra_en) wr_word({1'b0, extra});
    idle(2 * ho + 6 * hn + 8);
    f = -1;
    for (int i = i0; i < ph_n; i++)
      if (f < 0 && ph_len[i] == hn && ph_start[i] > w) f = i;
    chk(f >= 0, {req, " new length reached"}, f, 0);
    if (f >= 0) begin
      chk(ph_lvl[f] == 1'b1, {req, " R5 first new phase high"}, int'(ph_lvl[f]), 1);
      lat = ph_start[f] - w;
      chk(lat >= 1 && lat <= 2 * ho, {req, " R5 latency"}, lat, 2 * ho);
      bad = 0; badv = 0;
      for (int i = i0; i < f; i++)
        if (ph_len[i] != ho) begin bad++; badv = ph_len[i]; end
      chk(bad == 0, {req, " R4 old phases whole"}, badv, ho);
      bad = 0; cnt = 0;
      for (int i = f; i < ph_n; i++) begin
        cnt++;
        if (ph_len[i] != hn) begin bad++; badv = ph_len[i]; end
      end
      chk(bad == 0 && cnt >= 3, {req, " R4 new phases"}, badv, hn);
    end
    cur_k = newk;
  endtask

  task automatic t_reset();
    int bad;
    logic p;
    rst_n = 1'b0; clko_en = 1'b1; io_out = 1'b0;
    idle(3);
    p = clko; bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (clko === p) bad++;
      p = clko;
    end
    chk(bad == 0, "R8 pin toggles in reset", bad, 0);
    rst_n = 1'b1;
    idle(2);
    cur_k = 0;
    steady("R1 reset setting");
  endtask

  task automatic t_clken(input string req);
    int bad, rises, pulses;
    logic p, e;
    bad = 0; rises = 0; pulses = 0;
    p = sclk; e = en;
    for (int i = 0; i < 4 * (2 << cur_k) + 4; i++) begin
      @(negedge clk);
      if (e) begin pulses++; if (!(sclk && !p)) bad++; end
      if (sclk && !p) begin rises++; if (!e) bad++; end
      p = sclk; e = en;
    end
    chk(bad == 0, {req, " enable aligned to rise"}, bad, 0);
    chk(rises >= 3 && pulses == rises, {req, " enable count"}, pulses, rises);
  endtask

  task automatic t_codes();
    change(4'd3, 3, 0, 1'b0, 4'd0, "R2 code 3");
    change(4'd1, 1, 0, 1'b0, 4'd0, "R2 code 1");
    change(4'd6, 6, 0, 1'b0, 4'd0, "R2 code 6");
    change(4'd2, 2, 0, 1'b0, 4'd0, "R2 code 2");
    change(4'd8, 8, 0, 1'b0, 4'd0, "R2 code 8");
    change(4'd0, 0, 0, 1'b0, 4'd0, "R2 code 0");
  endtask

  task automatic t_reserved();
    change(4'd3,  3, 0, 1'b0, 4'd0, "R2 setup");
    change(4'd12, 0, 0, 1'b0, 4'd0, "R2 reserved 12");
    change(4'd2,  2, 0, 1'b0, 4'd0, "R2 setup");
    change(4'd15, 0, 0, 1'b0, 4'd0, "R2 reserved 15");
    change(4'd2,  2, 0, 1'b0, 4'd0, "R2 setup");
  endtask

  task automatic t_lock();
    wr_word(5'h05);
    steady("R3 no unlock");
    wr_word(5'h10);
    idle(4);
    wr_word(5'h05);
    steady("R3 late write");
    change(4'd5, 5, 3, 1'b0, 4'd0, "R3 last slot");
    change(4'd1, 1, 0, 1'b1, 4'd3, "R3 window closes");
  endtask

  task automatic t_override();
    int i0, bad, badv, cnt;
    logic p;
    change(4'd6, 6, 0, 1'b0, 4'd0, "R9 setup");
    p = sclk;
    forever begin
      @(negedge clk);
      if (sclk && !p) break;
      p = sclk;
    end
    i0 = ph_n;
    wr_word(5'h10); wr_word(5'h02);
    wr_word(5'h10); wr_word(5'h04);
    idle(2 * 64 + 6 * 16 + 8);
    bad = 0; badv = 0; cnt = 0;
    for (int i = i0; i < ph_n; i++) begin
      if (ph_len[i] != 64 && ph_len[i] != 16) begin bad++; badv = ph_len[i]; end
      if (ph_len[i] == 16) cnt++;
    end
    chk(bad == 0, "R9 earlier code never applied", badv, 16);
    chk(cnt >= 3 && ph_len[ph_n-1] == 16, "R9 later code active", ph_len[ph_n-1], 16);
    cur_k = 4;
  endtask

  task automatic t_pin();
    int bad;
    clko_en = 1'b0; io_out = 1'b1;
    idle(1);
    chk(clko == 1'b1, "R7 pin data high", int'(clko), 1);
    io_out = 1'b0;
    idle(1);
    chk(clko == 1'b0, "R7 pin data low", int'(clko), 0);
    clko_en = 1'b1;
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clko !== sclk) bad++;
    end
    chk(bad == 0, "R7 pin carries divided clock", bad, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_clken("R1");
    t_codes();
    t_reserved();
    t_lock();
    t_override();
    t_clken("R6");
    t_pin();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule